// File: doc/BRIEF.md
# Prioritized Core Interrupt Selector

This block sits in front of a processor core. It collects interrupt requests into a 16-entry pending flag register and picks the one to deliver. Each cycle it looks at every vector that is pending and eligible. It presents the lowest-numbered one as a one-cycle take strobe carrying a 4-bit vector number.

- Vectors 4 to 15 are general sources. Each is fed by a level-sensitive request line and is gated by its own enable bit and by one global enable.
- Vector 0 is a soft reset request and vector 1 is a non-maskable request. Both are captured on a rising edge, ignore every enable, and outrank all general vectors.
- Vectors 2 and 3 are reserved and never become pending.

Taking an interrupt clears its pending flag. It also copies the global enable into a shadow bit and then clears the global enable. A return strobe copies the shadow bit back.

Software reaches the state through a small register port. The port offers:
- the enable register;
- a write-one-to-set port and a write-one-to-clear port for general pending flags;
- the control word;
- a save address that returns the control word while clearing the global enable.

Top module: `core_irq_sel`

## Requirements
- R1: After reset the pending flags, the stored general enables, the global enable, the shadow bit and the take strobe are all 0.
- R2: A high level on general request line i sets pending flag 4+i at the next clock edge. The flag stays set after the line falls. A line held high sets the flag again on the edge after a take has cleared it.
- R3: Among eligible pending vectors, the lowest vector number is taken. Vector 0 ranks above vector 1, which ranks above vector 4, and vector 15 ranks last.
- R4: A general vector (4..15) is taken only while both its enable bit and the global enable are 1.
- R5: A rising edge on the reset or NMI request input sets pending flag 0 or 1 respectively. That flag is taken on the next edge regardless of the enable register and global enable, and a level held high does not retrigger.
- R6: A take is reported as `take_o`=1 for one cycle, with `take_vec_o` set, in the cycle after the selection. On the same edge the taken flag is cleared, the shadow bit receives the old global enable, and the global enable becomes 0. Clearing by a take wins over any set in the same cycle.
- R7: A cycle with `ret_i`=1 and no take copies the shadow bit into the global enable.
- R8: Address 1 (write) sets and address 2 (write) clears the pending flags whose data bits are 1, for bits 4..15 only. Data bits 0..3 have no effect, so writing 0xFFFF to address 2 leaves an NMI flag captured in the same cycle set.
- R9: Address 4 reads the control word. A write to address 4 clears the global enable and keeps the shadow bit, so a read and write in the same cycle return the value held before the clear.
- R10: Address 0 reads the enable register. Bits 0 and 1 read as 1, bits 2 and 3 read as 0, and only bits 4..15 are writable. Addresses 1 and 2 read the pending flags. Address 3 reads and writes the control word, with bit 0 the global enable and bit 1 the shadow.
- R11: Pending flags 2 and 3 always read 0, and vectors 2 and 3 are never taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| gen_req_i | input | 12 | Level request lines for vectors 4..15 (bit i feeds vector 4+i) |
| sreset_req_i | input | 1 | Soft reset request, rising-edge captured into vector 0 |
| nmi_req_i | input | 1 | Non-maskable request, rising-edge captured into vector 1 |
| ret_i | input | 1 | Return strobe, restores global enable from shadow |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register address (0 enable, 1 set, 2 clear, 3 control, 4 save) |
| reg_wdata_i | input | 16 | Register write data |
| reg_rdata_o | output | 16 | Register read data for reg_addr_i, combinational |
| take_o | output | 1 | One-cycle take strobe |
| take_vec_o | output | 4 | Number of the taken vector, valid with take_o |

## Verification
The hardest case to reach from the ports is a collision inside one clock edge. Examples are an NMI edge arriving with the global enable being written, or an NMI flag being captured while software clears every pending bit. The bench lines these up by driving the request input and the register write together, ahead of the same edge. A general level held high through its own take shows the re-arming of level sources. A seeded random phase piles several general patterns into the pending register with the global enable off, then releases them one return at a time and checks strict ascending order.

// File: rtl/core_irq_pkg.sv
package core_irq_pkg;

    localparam int NUM_VEC  = 16;
    localparam int GEN_BASE = 4;
    localparam int VEC_W    = $clog2(NUM_VEC);

    localparam int VEC_SRST = 0;
    localparam int VEC_NMI  = 1;

    typedef enum logic [2:0] {
        RA_ENABLE = 3'd0,
        RA_SET    = 3'd1,
        RA_CLEAR  = 3'd2,
        RA_CTRL   = 3'd3,
        RA_SAVE   = 3'd4
    } reg_addr_e;

    typedef struct packed {
        logic shadow;
        logic gie;
    } ctrl_t;

    typedef struct packed {
        logic             vld;
        logic [VEC_W-1:0] vec;
    } pick_t;

endpackage

// File: rtl/irq_pend_flags.sv
module irq_pend_flags #(
    parameter int NVEC  = 16,
    parameter int GBASE = 4,
    localparam int NGEN = NVEC - GBASE
) (
    input  logic            clk_i,
    input  logic            rst_i,
    input  logic [NGEN-1:0] lvl_i,
    input  logic            srst_lvl_i,
    input  logic            nmi_lvl_i,
    input  logic [NVEC-1:0] sw_set_i,
    input  logic [NVEC-1:0] sw_clr_i,
    input  logic [NVEC-1:0] take_oh_i,
    output logic [NVEC-1:0] pend_o
);

    logic            srst_d, nmi_d;
    logic            srst_rise, nmi_rise;
    logic [NVEC-1:0] pend_q;
    logic [NVEC-1:0] pend_nxt;

    assign srst_rise = srst_lvl_i & ~srst_d;
    assign nmi_rise  = nmi_lvl_i  & ~nmi_d;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            srst_d <= 1'b0;
            nmi_d  <= 1'b0;
        end else begin
            srst_d <= srst_lvl_i;
            nmi_d  <= nmi_lvl_i;
        end
    end

    for (genvar b = 0; b < NVEC; b++) begin : g_bit
        if (b == 0) begin : g_srst
            assign pend_nxt[b] = (pend_q[b] | srst_rise) & ~take_oh_i[b];
        end else if (b == 1) begin : g_nmi
            assign pend_nxt[b] = (pend_q[b] | nmi_rise) & ~take_oh_i[b];
        end else if (b < GBASE) begin : g_rsvd
            assign pend_nxt[b] = 1'b0;
        end else begin : g_gen
            assign pend_nxt[b] = (pend_q[b] | lvl_i[b-GBASE] | sw_set_i[b])
                               & ~(sw_clr_i[b] | take_oh_i[b]);
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) pend_q <= '0;
        else       pend_q <= pend_nxt;
    end

    assign pend_o = pend_q;

endmodule

// File: rtl/irq_ctrl_regs.sv
module irq_ctrl_regs
    import core_irq_pkg::*;
#(
    parameter int NVEC  = 16,
    parameter int GBASE = 4,
    localparam int NGEN = NVEC - GBASE
) (
    input  logic            clk_i,
    input  logic            rst_i,
    input  logic            wr_ena_i,
    input  logic [NGEN-1:0] ena_wdata_i,
    input  logic            wr_ctrl_i,
    input  ctrl_t           ctrl_wdata_i,
    input  logic            wr_save_i,
    input  logic            take_i,
    input  logic            ret_i,
    output logic [NVEC-1:0] ena_o,
    output ctrl_t           ctrl_o
);

    logic [NGEN-1:0] gen_ena_q;
    ctrl_t           ctrl_q;

    always_ff @(posedge clk_i) begin
        if (rst_i)         gen_ena_q <= '0;
        else if (wr_ena_i) gen_ena_q <= ena_wdata_i;
    end

    // take outranks return, which outranks software writes
    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            ctrl_q <= '0;
        end else if (take_i) begin
            ctrl_q.shadow <= ctrl_q.gie;
            ctrl_q.gie    <= 1'b0;
        end else if (ret_i) begin
            ctrl_q.gie    <= ctrl_q.shadow;
        end else if (wr_ctrl_i) begin
            ctrl_q        <= ctrl_wdata_i;
        end else if (wr_save_i) begin
            ctrl_q.gie    <= 1'b0;
        end
    end

    for (genvar b = 0; b < GBASE; b++) begin : g_fixed
        if (b == VEC_SRST || b == VEC_NMI) begin : g_on
            assign ena_o[b] = 1'b1;
        end else begin : g_off
            assign ena_o[b] = 1'b0;
        end
    end
    assign ena_o[NVEC-1:GBASE] = gen_ena_q;
    assign ctrl_o              = ctrl_q;

endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
    parameter int NVEC  = 16,
    parameter int GBASE = 4,
    localparam int VW   = $clog2(NVEC)
) (
    input  logic [NVEC-1:0] pend_i,
    input  logic [NVEC-1:0] ena_i,
    input  logic            gie_i,
    output logic            vld_o,
    output logic [VW-1:0]   vec_o
);

    logic [NVEC-1:0] elig;

    for (genvar b = 0; b < NVEC; b++) begin : g_elig
        if (b < 2) begin : g_nomask
            assign elig[b] = pend_i[b];
        end else if (b < GBASE) begin : g_rsvd
            assign elig[b] = 1'b0;
        end else begin : g_gen
            assign elig[b] = pend_i[b] & ena_i[b] & gie_i;
        end
    end

    // scan from the top down so the lowest eligible number is left standing
    always_comb begin
        vld_o = 1'b0;
        vec_o = '0;
        for (int i = NVEC - 1; i >= 0; i--) begin
            if (elig[i]) begin
                vld_o = 1'b1;
                vec_o = VW'(i);
            end
        end
    end

endmodule

// File: rtl/core_irq_sel.sv
module core_irq_sel
    import core_irq_pkg::*;
#(
    parameter int  NVEC  = NUM_VEC,
    parameter int  GBASE = GEN_BASE,
    localparam int NGEN  = NVEC - GBASE,
    localparam int VW    = $clog2(NVEC)
) (
    input  logic            clk_i,
    input  logic            rst_i,
    input  logic [NGEN-1:0] gen_req_i,
    input  logic            sreset_req_i,
    input  logic            nmi_req_i,
    input  logic            ret_i,
    input  logic            reg_wr_i,
    input  logic [2:0]      reg_addr_i,
    input  logic [NVEC-1:0] reg_wdata_i,
    output logic [NVEC-1:0] reg_rdata_o,
    output logic            take_o,
    output logic [VW-1:0]   take_vec_o
);

    reg_addr_e       addr;
    logic [NVEC-1:0] pend;
    logic [NVEC-1:0] ena;
    ctrl_t           ctrl;
    logic            pick_vld;
    logic [VW-1:0]   pick_vec;
    logic [NVEC-1:0] take_oh;
    logic [NVEC-1:0] gen_mask;
    logic [NVEC-1:0] sw_set, sw_clr;
    logic            wr_ena, wr_ctrl, wr_save;
    logic            take_q;
    logic [VW-1:0]   take_vec_q;

    assign addr = reg_addr_e'(reg_addr_i);

    for (genvar b = 0; b < NVEC; b++) begin : g_mask
        assign gen_mask[b] = (b >= GBASE);
        assign take_oh[b]  = pick_vld && (pick_vec == VW'(b));
    end

    assign wr_ena  = reg_wr_i && (addr == RA_ENABLE);
    assign wr_ctrl = reg_wr_i && (addr == RA_CTRL);
    assign wr_save = reg_wr_i && (addr == RA_SAVE);
    assign sw_set  = (reg_wr_i && addr == RA_SET)   ? (reg_wdata_i & gen_mask) : '0;
    assign sw_clr  = (reg_wr_i && addr == RA_CLEAR) ? (reg_wdata_i & gen_mask) : '0;

    irq_pend_flags #(.NVEC(NVEC), .GBASE(GBASE)) u_pend (
        .clk_i      (clk_i),
        .rst_i      (rst_i),
        .lvl_i      (gen_req_i),
        .srst_lvl_i (sreset_req_i),
        .nmi_lvl_i  (nmi_req_i),
        .sw_set_i   (sw_set),
        .sw_clr_i   (sw_clr),
        .take_oh_i  (take_oh),
        .pend_o     (pend)
    );

    irq_ctrl_regs #(.NVEC(NVEC), .GBASE(GBASE)) u_ctrl (
        .clk_i        (clk_i),
        .rst_i        (rst_i),
        .wr_ena_i     (wr_ena),
        .ena_wdata_i  (reg_wdata_i[NVEC-1:GBASE]),
        .wr_ctrl_i    (wr_ctrl),
        .ctrl_wdata_i (ctrl_t'(reg_wdata_i[1:0])),
        .wr_save_i    (wr_save),
        .take_i       (pick_vld),
        .ret_i        (ret_i),
        .ena_o        (ena),
        .ctrl_o       (ctrl)
    );

    irq_prio_pick #(.NVEC(NVEC), .GBASE(GBASE)) u_pick (
        .pend_i (pend),
        .ena_i  (ena),
        .gie_i  (ctrl.gie),
        .vld_o  (pick_vld),
        .vec_o  (pick_vec)
    );

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            take_q     <= 1'b0;
            take_vec_q <= '0;
        end else begin
            take_q     <= pick_vld;
            take_vec_q <= pick_vld ? pick_vec : take_vec_q;
        end
    end

    always_comb begin
        case (addr)
            RA_ENABLE:         reg_rdata_o = ena;
            RA_SET, RA_CLEAR:  reg_rdata_o = pend;
            RA_CTRL, RA_SAVE:  reg_rdata_o = NVEC'(ctrl);
            default:           reg_rdata_o = '0;
        endcase
    end

    assign take_o     = take_q;
    assign take_vec_o = take_vec_q;

endmodule

// File: rtl/core_irq_sel_chk.sv
module core_irq_sel_chk #(
    parameter int  NVEC  = 16,
    parameter int  GBASE = 4,
    localparam int VW    = $clog2(NVEC)
) (
    input logic            clk_i,
    input logic            rst_i,
    input logic [NVEC-1:0] pend,
    input logic [NVEC-1:0] ena,
    input logic            gie,
    input logic            shadow,
    input logic            pick_vld,
    input logic            ret_i,
    input logic            take_o,
    input logic [VW-1:0]   take_vec_o
);

    // R11
    rsvd_idle_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        pend[3:2] == 2'b00);

    // R6
    take_gie_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        take_o |-> (!gie && (shadow == $past(gie))));

    // R6
    take_clr_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        take_o |-> !pend[take_vec_o]);

    // R4
    take_gen_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (take_o && take_vec_o >= VW'(GBASE)) |->
            ($past(gie) && ((($past(ena) >> take_vec_o) & NVEC'(1)) != '0)));

    // R7
    ret_restore_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (ret_i && !pick_vld) |=> (gie == $past(shadow)));

    // R11
    take_rsvd_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        take_o |-> (take_vec_o != VW'(2) && take_vec_o != VW'(3)));

endmodule

bind core_irq_sel core_irq_sel_chk #(.NVEC(NVEC), .GBASE(GBASE)) u_chk (
    .clk_i      (clk_i),
    .rst_i      (rst_i),
    .pend       (pend),
    .ena        (ena),
    .gie        (ctrl.gie),
    .shadow     (ctrl.shadow),
    .pick_vld   (pick_vld),
    .ret_i      (ret_i),
    .take_o     (take_o),
    .take_vec_o (take_vec_o)
);

// File: tb/tb_core_irq_sel.sv
`timescale 1ns/1ps
module tb_core_irq_sel;

    logic        clk = 1'b0;
    logic        rst;
    logic [11:0] gen_req;
    logic        sreset_req, nmi_req, ret;
    logic        reg_wr;
    logic [2:0]  reg_addr;
    logic [15:0] reg_wdata;
    logic [15:0] reg_rdata;
    logic        take;
    logic [3:0]  take_vec;

    int n_run  = 0;
    int n_fail = 0;
    logic [15:0] rv;

    always #2 clk = ~clk;

    core_irq_sel dut (
        .clk_i        (clk),
        .rst_i        (rst),
        .gen_req_i    (gen_req),
        .sreset_req_i (sreset_req),
        .nmi_req_i    (nmi_req),
        .ret_i        (ret),
        .reg_wr_i     (reg_wr),
        .reg_addr_i   (reg_addr),
        .reg_wdata_i  (reg_wdata),
        .reg_rdata_o  (reg_rdata),
        .take_o       (take),
        .take_vec_o   (take_vec)
    );

    localparam logic [2:0] A_ENA = 3'd0, A_SET = 3'd1, A_CLR = 3'd2,
                           A_CTL = 3'd3, A_SAV = 3'd4;

    function automatic int lowest(input logic [15:0] v);
        for (int i = 0; i < 16; i++) if (v[i]) return i;
        return -1;
    endfunction

    task automatic step();
        @(posedge clk); #1;
    endtask

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic chk_take(input string req, input logic exp_t, input int exp_v);
        n_run++;
        if (take !== exp_t || (exp_t && take_vec !== exp_v[3:0])) begin
            n_fail++;
            $display("FAIL %s actual=take%0b/vec%0d expected=take%0b/vec%0d",
                     req, take, take_vec, exp_t, exp_v);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        step();
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [15:0] d);
        reg_addr = a; #1; d = reg_rdata;
    endtask

    task automatic ret_pulse();
        ret = 1'b1; step(); ret = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        logic [15:0] exp_p;
        logic [15:0] pat;
        rst = 1'b1; gen_req = '0; sreset_req = 0; nmi_req = 0; ret = 0;
        reg_wr = 0; reg_addr = '0; reg_wdata = '0;
        void'($urandom(32'd4242));
        repeat (3) step();
        rst = 1'b0;
        step();

        // R1 reset state
        chk_take("R1 take", 1'b0, 0);
        rd(A_ENA, rv); check("R1 enable", rv, 16'h0003);
        rd(A_SET, rv); check("R1 pending", rv, 16'h0000);
        rd(A_CTL, rv); check("R1 ctrl", rv, 16'h0000);

        // R10 fixed enable bits
        wr(A_ENA, 16'hFFFF);
        rd(A_ENA, rv); check("R10 enable fixed bits", rv, 16'hFFF3);
        wr(A_ENA, 16'h0000);

        // R8 / R11 set ignores low bits
        wr(A_SET, 16'h010F);
        rd(A_SET, rv); check("R8 R11 set low bits ignored", rv, 16'h0100);
        wr(A_ENA, 16'h0100);
        step(); step();
        chk_take("R4 no take with gie 0", 1'b0, 0);

        // R8 clear-all in the cycle an NMI edge lands
        nmi_req = 1'b1;
        wr(A_CLR, 16'hFFFF);
        rd(A_CLR, rv); check("R8 clear keeps nmi flag", rv, 16'h0002);
        step();
        chk_take("R5 nmi taken with gie 0", 1'b1, 1);
        step();
        chk_take("R5 nmi level no retrigger", 1'b0, 0);
        nmi_req = 1'b0;

        // R3 / R4 / R6 masked vs enabled general
        wr(A_SET, 16'h0240);
        wr(A_ENA, 16'h0200);
        wr(A_CTL, 16'h0001);
        step();
        chk_take("R4 only enabled vec 9", 1'b1, 9);
        rd(A_SET, rv); check("R6 taken flag cleared", rv, 16'h0040);
        rd(A_CTL, rv); check("R6 gie to shadow", rv, 16'h0002);
        step();
        chk_take("R6 single cycle strobe", 1'b0, 0);
        ret_pulse();
        rd(A_CTL, rv); check("R7 ret restores gie", rv, 16'h0003);
        step();
        chk_take("R4 vec 6 still masked", 1'b0, 0);
        wr(A_ENA, 16'h0240);
        step();
        chk_take("R3 vec 6 after enable", 1'b1, 6);

        // R9 save read and clear
        ret_pulse();
        reg_addr = A_SAV; reg_wr = 1'b1; reg_wdata = '0; #1;
        check("R9 save returns old", reg_rdata, 16'h0003);
        step(); reg_wr = 1'b0;
        rd(A_CTL, rv); check("R9 save cleared gie", rv, 16'h0002);

        // R5 reset request above nmi
        sreset_req = 1'b1; nmi_req = 1'b1;
        step();
        rd(A_SET, rv); check("R5 both edges pending", rv, 16'h0003);
        step();
        chk_take("R5 reset first", 1'b1, 0);
        step();
        chk_take("R5 nmi second", 1'b1, 1);
        sreset_req = 1'b0; nmi_req = 1'b0;
        step();

        // R3 / R5 nmi beats enabled general vec 4
        wr(A_SET, 16'h0010);
        wr(A_ENA, 16'h0010);
        nmi_req = 1'b1;
        wr(A_CTL, 16'h0001);
        step();
        chk_take("R3 nmi over vec 4", 1'b1, 1);
        nmi_req = 1'b0;
        step();
        chk_take("R6 gie off after nmi", 1'b0, 0);
        ret_pulse();
        step();
        chk_take("R3 vec 4 after return", 1'b1, 4);

        // R2 level held through its take
        gen_req[5] = 1'b1;
        wr(A_ENA, 16'h0200);
        ret_pulse();
        step();
        chk_take("R2 level vec 9 taken", 1'b1, 9);
        step();
        rd(A_SET, rv); check("R2 level re-arms", rv, 16'h0200);
        gen_req = '0;
        step();
        rd(A_SET, rv); check("R2 flag latched after drop", rv, 16'h0200);
        wr(A_CLR, 16'h0200);
        rd(A_SET, rv); check("R8 clear general", rv, 16'h0000);

        // random accumulation then ordered release
        for (int round = 0; round < 4; round++) begin
            exp_p = '0;
            wr(A_CTL, 16'h0000);
            wr(A_ENA, 16'hFFF0);
            for (int k = 0; k < 3; k++) begin
                pat = 16'($urandom) & 16'hFFF0;
                gen_req = pat[15:4];
                step();
                gen_req = '0;
                exp_p |= pat;
            end
            rd(A_SET, rv); check("R2 random accumulate", rv, exp_p);
            wr(A_CTL, 16'h0001);
            while (exp_p != 16'h0000) begin
                step();
                chk_take("R3 random order", 1'b1, lowest(exp_p));
                exp_p[lowest(exp_p)] = 1'b0;
                rd(A_SET, rv); check("R6 random clear", rv, exp_p);
                ret_pulse();
            end
            step();
            chk_take("R3 random drained", 1'b0, 0);
        end

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule